// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block produces the low address bits used during a four-beat burst on a synchronous burst memory. At the start of an access the controller drives a starting low address and holds the step/load control low. The block captures that address and restarts its beat count. While the control is held high, each enabled clock moves the block one beat further through the burst. The output is the effective low address for the current beat. Outside the block it is joined to a separately registered upper address.

The beat order is chosen by a static order select. One setting gives an XOR-style interleaved order and the other gives a wrap-around linear order. A suspend input freezes the whole block so that the clock edge has no effect. Once the last beat of a burst has been reached, further advances wrap around and repeat the same sequence.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, the beat count and the captured start are cleared, so burst_addr_o reads 0 right after reset.
- R2: On a clock edge with suspend_i low and step_nload_i low, start_addr_i is captured and the beat count returns to 0, so burst_addr_o equals that start address in the following cycle.
- R3: On a clock edge with suspend_i low and step_nload_i high, the beat count rises by one, modulo the burst length of 4 beats.
- R4: With order_i = 1 (interleaved), burst_addr_o is the captured start XOR the beat count. For example, start 1 gives 1,0,3,2 and start 3 gives 3,2,1,0.
- R5: With order_i = 0 (linear), burst_addr_o is the captured start plus the beat count, modulo 4. For example, start 1 gives 1,2,3,0 and start 3 gives 3,0,1,2.
- R6: An advance after the fourth beat wraps around to the start address and continues the same sequence. It does not stop or reload.
- R7: While suspend_i is high, both step_nload_i and start_addr_i are ignored. The beat count and captured start are held, so burst_addr_o stays unchanged as long as order_i is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| suspend_i | input | 1 | High freezes the block (clock edge ignored) |
| step_nload_i | input | 1 | High: advance one beat; low: load start address |
| order_i | input | 1 | 1: interleaved order, 0: linear order |
| start_addr_i | input | LO_W (2) | Starting low address for a new burst |
| burst_addr_o | output | LO_W (2) | Effective low address of the current beat |

## Verification
The bench builds the block with its default low-address width of 2, which gives four beats. With this setting every start value, every beat and both orderings can be reached, and so can the wrap from the fourth beat back to the first. The run applies directed bursts, running each past its fourth beat, for several start values in both orders. It also applies a suspend stretch that carries conflicting load and advance requests. A long random mix of loads, advances, suspends and order changes follows. The output is compared on every clock against a behavioural model that holds a start value and an unbounded beat integer.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int LO_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            suspend_i,
  input  logic            step_nload_i,
  output logic [LO_W-1:0] step_o
);
  typedef logic [LO_W-1:0] step_t;
  step_t step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        step_q <= '0;
    else if (!suspend_i && !step_nload_i) step_q <= '0;
    else if (!suspend_i)                step_q <= step_q + step_t'(1);
  end

  assign step_o = step_q;

  AST_LOAD_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!suspend_i && !step_nload_i) |=> (step_q == '0)); // R2
  AST_STEP_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!suspend_i && step_nload_i) |=> (step_q == step_t'($past(step_q) + 1'b1))); // R3
  AST_STEP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> $stable(step_q)); // R7
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int LO_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            suspend_i,
  input  logic            step_nload_i,
  input  logic [LO_W-1:0] start_addr_i,
  output logic [LO_W-1:0] start_o
);
  logic [LO_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        start_q <= '0;
    else if (!suspend_i && !step_nload_i) start_q <= start_addr_i;
  end

  assign start_o = start_q;

  AST_START_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i || step_nload_i) |=> $stable(start_q)); // R7
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int LO_W = 2
) (
  input  logic            order_i,
  input  logic [LO_W-1:0] start_i,
  input  logic [LO_W-1:0] step_i,
  output logic [LO_W-1:0] addr_o
);
  logic [LO_W-1:0] lin_addr;
  logic [LO_W-1:0] ilv_addr;

  assign lin_addr = start_i + step_i;  // wraps at burst length
  assign ilv_addr = start_i ^ step_i;

  always_comb begin
    unique case (burst_order_e'(order_i))
      ORD_INTERLEAVE: addr_o = ilv_addr;
      default:        addr_o = lin_addr;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int LO_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            suspend_i,
  input  logic            step_nload_i,
  input  logic            order_i,
  input  logic [LO_W-1:0] start_addr_i,
  output logic [LO_W-1:0] burst_addr_o
);
  logic [LO_W-1:0] step_w;
  logic [LO_W-1:0] start_w;

  burst_step_ctr #(.LO_W(LO_W)) u_step (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .suspend_i    (suspend_i),
    .step_nload_i (step_nload_i),
    .step_o       (step_w)
  );

  burst_start_reg #(.LO_W(LO_W)) u_start (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .suspend_i    (suspend_i),
    .step_nload_i (step_nload_i),
    .start_addr_i (start_addr_i),
    .start_o      (start_w)
  );

  burst_order_map #(.LO_W(LO_W)) u_map (
    .order_i (order_i),
    .start_i (start_w),
    .step_i  (step_w),
    .addr_o  (burst_addr_o)
  );

  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!suspend_i && !step_nload_i) |=> (burst_addr_o == $past(start_addr_i))); // R2
  AST_OUT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> ((order_i != $past(order_i)) || $stable(burst_addr_o))); // R7
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (burst_addr_o == '0)); // R1
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int LO_W = 2;
  localparam time TCK = 20ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            suspend = 1'b0;
  logic            step_nload = 1'b0;
  logic            order = 1'b0;
  logic [LO_W-1:0] start_addr = '0;
  logic [LO_W-1:0] burst_addr;

  int n_chk = 0;
  int n_fail = 0;
  int m_start = 0;
  int m_step = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #(TCK/2) clk = ~clk;

  burst_addr_gen #(.LO_W(LO_W)) u_burst_addr_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .suspend_i    (suspend),
    .step_nload_i (step_nload),
    .order_i      (order),
    .start_addr_i (start_addr),
    .burst_addr_o (burst_addr)
  );

  function automatic int model_addr(int s, int k, logic o);
    if (o) return (s ^ (k % 4)) % 4;
    return (s + k) % 4;
  endfunction

  // per-clock reference compare, then model update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0;
      m_step  = 0;
    end else begin
      n_chk++;
      if (int'(burst_addr) != model_addr(m_start, m_step, order)) begin
        n_fail++;
        $display("FAIL %s model: actual %0d expected %0d", cur_req, burst_addr,
                 model_addr(m_start, m_step, order));
      end
      if (!suspend) begin
        if (!step_nload) begin
          m_start = int'(start_addr);
          m_step  = 0;
        end else begin
          m_step = m_step + 1;
        end
      end
    end
  end

  task automatic chk(string req, int exp);
    n_chk++;
    if (int'(burst_addr) != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, burst_addr, exp);
    end
  endtask

  // load s, then take five beats (fifth shows the wrap, R6)
  task automatic run_burst(string req, logic o, int s, int e0, int e1, int e2, int e3);
    int exp[5];
    exp = '{e0, e1, e2, e3, e0};
    cur_req = req;
    @(negedge clk);
    order = o; suspend = 1'b0; step_nload = 1'b0; start_addr = LO_W'(s);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk((i == 0) ? "R2" : ((i == 4) ? "R6" : req), exp[i]);
      step_nload = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 0);

    run_burst("R5", 1'b0, 1, 1, 2, 3, 0);
    run_burst("R5", 1'b0, 3, 3, 0, 1, 2);
    run_burst("R5", 1'b0, 2, 2, 3, 0, 1);
    run_burst("R4", 1'b1, 1, 1, 0, 3, 2);
    run_burst("R4", 1'b1, 3, 3, 2, 1, 0);
    run_burst("R4", 1'b1, 2, 2, 3, 0, 1);
    run_burst("R3", 1'b1, 0, 0, 1, 2, 3);

    // R7: suspend with conflicting requests
    cur_req = "R7";
    @(negedge clk);
    order = 1'b0; step_nload = 1'b0; start_addr = 2'd2;
    @(negedge clk);
    step_nload = 1'b1;
    @(negedge clk);
    chk("R3", 3);
    suspend = 1'b1; step_nload = 1'b0; start_addr = 2'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7", 3);
      step_nload = ~step_nload;
    end
    suspend = 1'b0; step_nload = 1'b1;
    @(negedge clk);
    chk("R7", 0);

    // random mix, checked by the model
    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      suspend    = ($urandom_range(0, 3) == 0);
      step_nload = ($urandom_range(0, 3) != 0);
      start_addr = LO_W'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) order = ~order;
      cur_req = suspend ? "R7" : (step_nload ? (order ? "R4" : "R5") : "R2");
    end
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(TCK * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule